// File: doc/BRIEF.md
# Direct Segment Address Translator

This block is the translation front end of one core or hardware thread. It holds three registers that software programs: a segment base, a segment limit and an offset. Every virtual address presented to it is compared against the half-open range [base, limit). An address inside that range is translated by a single add of the offset. No TLB answer is used for it, and it can never start a page-table walk. Any other address takes the ordinary paging path, which is a lookup port towards a TLB that answers hit or miss.

The range compare runs in the same cycle as the TLB lookup issue. When the segment matches, the block answers one cycle after acceptance and drops the TLB answer when it arrives. For an address outside the segment, the block waits for the TLB answer and forwards it. On a TLB miss it also raises a walk request. Software can grow, shrink or empty the segment at run time. Each translation uses the register values that were present in its acceptance cycle.

Top module: `dseg_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `walk_valid` are 0, and base, limit and offset are all zero, so the segment is empty and the first request goes to the TLB.
- R2: An address hits the segment if and only if base <= vaddr < limit. An address equal to base hits, limit-1 hits, limit misses and base-1 misses.
- R3: On a segment hit, `rsp_valid` pulses in the cycle after acceptance with `rsp_paddr` = vaddr + offset and `rsp_src` = 1 (segment).
- R4: A non-hit address is answered in the cycle after the TLB answer. On a TLB hit the response has `rsp_src` = 2 and carries the TLB's physical address. On a TLB miss it has `rsp_src` = 3 and `rsp_paddr` = 0, and `walk_valid` pulses in the same cycle with `walk_vaddr` = the request address.
- R5: On a segment hit the TLB answer is discarded. It produces no second response and no walk request, even when the TLB reports a miss.
- R6: Register writes use `cfg_sel` 0 = base, 1 = limit, 2 = offset, and 3 is ignored. A base or limit write whose low 12 bits are not all zero is ignored and leaves the old value in place. Offset writes are taken as given.
- R7: When base >= limit no address hits the segment, and all traffic goes to the TLB.
- R8: A register write affects every request accepted after the write cycle. This allows the segment to be grown or shrunk at run time.
- R9: A request uses the register values from its acceptance cycle. A write in that same cycle, or while the request waits for the TLB, does not change its result.
- R10: If vaddr + offset (carry included) is 2^46 or more, a segment hit responds with `rsp_fault` = 1 and `rsp_paddr` = 0. Any other response has `rsp_fault` = 0.
- R11: Each accepted request raises `tlb_lkp_valid` in its acceptance cycle. `req_ready` is 0 from the cycle after acceptance until the cycle after that request's TLB answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 offset |
| cfg_wdata | input | 48 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| tlb_lkp_valid | output | 1 | TLB lookup issue |
| tlb_lkp_vaddr | output | 48 | Address looked up in the TLB |
| tlb_rsp_valid | input | 1 | TLB answer valid |
| tlb_rsp_hit | input | 1 | TLB answer is a hit |
| tlb_rsp_paddr | input | 46 | Physical address from the TLB |
| rsp_valid | output | 1 | Translation result valid (one-cycle pulse) |
| rsp_paddr | output | 46 | Translated physical address |
| rsp_fault | output | 1 | Segment add exceeded the physical width |
| rsp_src | output | 2 | Result source: 1 segment, 2 TLB hit, 3 TLB miss |
| walk_valid | output | 1 | Page-table walk request pulse |
| walk_vaddr | output | 48 | Address the walk must resolve |

## Verification
A wrong base or limit register, or an off-by-one compare, shows up at the ports on the next request near a boundary. That request returns the wrong source code one cycle after acceptance, or a walk pulse appears where none is due. A stale in-flight record shows up as a dropped response, a duplicate response or a walk for a segment address when the TLB answers, two cycles after the lookup. An offset or overflow error appears in the data or fault bit of the very next segment response. The bench therefore aims its addresses at base-1, base, limit-1 and limit under several register settings, including programming changes while a request is in flight.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

    localparam int unsigned DEF_VA_W       = 48;
    localparam int unsigned DEF_PA_W       = 46;
    localparam int unsigned DEF_PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_SEG      = 2'd1,
        SRC_TLB_HIT  = 2'd2,
        SRC_TLB_MISS = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic hit;
        logic ovf;
    } seg_res_t;

    // Returns 1 when the low `sh` bits of v are all zero.
    function automatic logic low_bits_clear(input logic [63:0] v, input int unsigned sh);
        logic [63:0] mask;
        mask = (64'd1 << sh) - 64'd1;
        return (v & mask) == 64'd0;
    endfunction

endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
    import dseg_pkg::*;
#(
    parameter int unsigned VA_W       = DEF_VA_W,
    parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [VA_W-1:0] cfg_wdata,
    output logic [VA_W-1:0] seg_base,
    output logic [VA_W-1:0] seg_limit,
    output logic [VA_W-1:0] seg_offset
);

    localparam int unsigned EXT_W = 64;

    logic     wr_aligned;
    cfg_sel_e sel;

    assign sel        = cfg_sel_e'(cfg_sel);
    assign wr_aligned = low_bits_clear(EXT_W'(cfg_wdata), PAGE_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_base   <= '0;
            seg_limit  <= '0;
            seg_offset <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_BASE:   if (wr_aligned) seg_base  <= cfg_wdata;
                SEL_LIMIT:  if (wr_aligned) seg_limit <= cfg_wdata;
                SEL_OFFSET: seg_offset <= cfg_wdata;
                default: ;
            endcase
        end
    end

    AST_BASE_UNALIGNED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && sel == SEL_BASE && !wr_aligned) |=> $stable(seg_base)); // R6
    AST_LIMIT_UNALIGNED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && sel == SEL_LIMIT && !wr_aligned) |=> $stable(seg_limit)); // R6
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(seg_base) && $stable(seg_limit) && $stable(seg_offset))); // R8

endmodule

// File: rtl/dseg_match.sv
module dseg_match
    import dseg_pkg::*;
#(
    parameter int unsigned VA_W = DEF_VA_W,
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] seg_base,
    input  logic [VA_W-1:0] seg_limit,
    input  logic [VA_W-1:0] seg_offset,
    output seg_res_t        res,
    output logic [PA_W-1:0] paddr
);

    localparam int unsigned SUM_W = VA_W + 1;

    logic [SUM_W-1:0] sum;
    logic             above_base;
    logic             below_limit;
    logic             ovf;

    assign above_base  = (vaddr >= seg_base);
    assign below_limit = (vaddr <  seg_limit);
    assign sum         = {1'b0, vaddr} + {1'b0, seg_offset};

    generate
        if (PA_W < SUM_W) begin : g_trunc
            assign ovf   = |sum[SUM_W-1:PA_W];
            assign paddr = sum[PA_W-1:0];
        end else begin : g_wide
            assign ovf   = 1'b0;
            assign paddr = PA_W'(sum);
        end
    endgenerate

    assign res.hit = above_base && below_limit;
    assign res.ovf = ovf;

endmodule

// File: rtl/dseg_ctrl.sv
module dseg_ctrl
    import dseg_pkg::*;
#(
    parameter int unsigned VA_W = DEF_VA_W,
    parameter int unsigned PA_W = DEF_PA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  seg_res_t        seg_res,
    input  logic [PA_W-1:0] seg_paddr,
    output logic            tlb_lkp_valid,
    output logic [VA_W-1:0] tlb_lkp_vaddr,
    input  logic            tlb_rsp_valid,
    input  logic            tlb_rsp_hit,
    input  logic [PA_W-1:0] tlb_rsp_paddr,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output src_e            rsp_src,
    output logic            walk_valid,
    output logic [VA_W-1:0] walk_vaddr
);

    ctrl_state_e     state;
    logic            accept;
    logic            fl_seg;
    logic [VA_W-1:0] fl_vaddr;

    assign req_ready     = (state == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign tlb_lkp_valid = accept;
    assign tlb_lkp_vaddr = req_vaddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fl_seg     <= 1'b0;
            fl_vaddr   <= '0;
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_fault  <= 1'b0;
            rsp_src    <= SRC_NONE;
            walk_valid <= 1'b0;
            walk_vaddr <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            walk_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_WAIT;
                        fl_seg   <= seg_res.hit;
                        fl_vaddr <= req_vaddr;
                        if (seg_res.hit) begin
                            rsp_valid <= 1'b1;
                            rsp_src   <= SRC_SEG;
                            rsp_fault <= seg_res.ovf;
                            rsp_paddr <= seg_res.ovf ? '0 : seg_paddr;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tlb_rsp_valid) begin
                        state <= ST_IDLE;
                        if (!fl_seg) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            if (tlb_rsp_hit) begin
                                rsp_src   <= SRC_TLB_HIT;
                                rsp_paddr <= tlb_rsp_paddr;
                            end else begin
                                rsp_src    <= SRC_TLB_MISS;
                                rsp_paddr  <= '0;
                                walk_valid <= 1'b1;
                                walk_vaddr <= fl_vaddr;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SEG_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (accept && seg_res.hit) |=> (rsp_valid && rsp_src == SRC_SEG)); // R3
    AST_SEG_NO_WALK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && fl_seg && tlb_rsp_valid) |=> (!walk_valid && !rsp_valid)); // R5
    AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        walk_valid |-> (rsp_valid && rsp_src == SRC_TLB_MISS)); // R4
    AST_FAULT_SEG_ONLY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_src == SRC_SEG)); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R11
    AST_READY_AFTER_TLB: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && tlb_rsp_valid) |=> req_ready); // R11

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
    import dseg_pkg::*;
#(
    parameter int unsigned VA_W       = DEF_VA_W,
    parameter int unsigned PA_W       = DEF_PA_W,
    parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [VA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            tlb_lkp_valid,
    output logic [VA_W-1:0] tlb_lkp_vaddr,
    input  logic            tlb_rsp_valid,
    input  logic            tlb_rsp_hit,
    input  logic [PA_W-1:0] tlb_rsp_paddr,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic [1:0]      rsp_src,
    output logic            walk_valid,
    output logic [VA_W-1:0] walk_vaddr
);

    logic [VA_W-1:0] seg_base;
    logic [VA_W-1:0] seg_limit;
    logic [VA_W-1:0] seg_offset;
    seg_res_t        seg_res;
    logic [PA_W-1:0] seg_paddr;
    src_e            src;

    dseg_regs #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .seg_offset (seg_offset)
    );

    dseg_match #(.VA_W(VA_W), .PA_W(PA_W)) u_match (
        .vaddr      (req_vaddr),
        .seg_base   (seg_base),
        .seg_limit  (seg_limit),
        .seg_offset (seg_offset),
        .res        (seg_res),
        .paddr      (seg_paddr)
    );

    dseg_ctrl #(.VA_W(VA_W), .PA_W(PA_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .seg_res       (seg_res),
        .seg_paddr     (seg_paddr),
        .tlb_lkp_valid (tlb_lkp_valid),
        .tlb_lkp_vaddr (tlb_lkp_vaddr),
        .tlb_rsp_valid (tlb_rsp_valid),
        .tlb_rsp_hit   (tlb_rsp_hit),
        .tlb_rsp_paddr (tlb_rsp_paddr),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_src       (src),
        .walk_valid    (walk_valid),
        .walk_vaddr    (walk_vaddr)
    );

    assign rsp_src = src;

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (seg_base >= seg_limit) |-> !seg_res.hit); // R7
    AST_BOUND_LIMIT_MISS: assert property (@(posedge clk) disable iff (rst)
        (req_vaddr == seg_limit) |-> !seg_res.hit); // R2

endmodule

// File: tb/sim_dseg_xlate.sv
module sim_dseg_xlate;

    localparam int VA_W = 48;
    localparam int PA_W = 46;

    typedef struct {
        logic [PA_W-1:0] pa;
        logic            fault;
        logic [1:0]      src;
        string           req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_sel = 2'd0;
    logic [VA_W-1:0] cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            tlb_lkp_valid;
    logic [VA_W-1:0] tlb_lkp_vaddr;
    logic            tlb_rsp_valid;
    logic            tlb_rsp_hit;
    logic [PA_W-1:0] tlb_rsp_paddr;
    logic            rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic            rsp_fault;
    logic [1:0]      rsp_src;
    logic            walk_valid;
    logic [VA_W-1:0] walk_vaddr;

    int n_checks = 0;
    int n_fail   = 0;
    int n_req    = 0;
    int n_lkp    = 0;

    exp_t            rq[$];
    logic [VA_W-1:0] wq[$];

    logic [VA_W-1:0] m_base = '0;
    logic [VA_W-1:0] m_limit = '0;
    logic [VA_W-1:0] m_off = '0;

    always #10 clk = ~clk;

    dseg_xlate u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .tlb_lkp_valid(tlb_lkp_valid), .tlb_lkp_vaddr(tlb_lkp_vaddr),
        .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_hit(tlb_rsp_hit), .tlb_rsp_paddr(tlb_rsp_paddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_src(rsp_src),
        .walk_valid(walk_valid), .walk_vaddr(walk_vaddr)
    );

    // TLB model: two-cycle latency, hit when address bit 12 is 0.
    logic            t1_v = 1'b0, t2_v = 1'b0;
    logic [VA_W-1:0] t1_a = '0, t2_a = '0;
    always @(posedge clk) begin
        t1_v <= tlb_lkp_valid && !rst;
        t1_a <= tlb_lkp_vaddr;
        t2_v <= t1_v && !rst;
        t2_a <= t1_a;
    end
    assign tlb_rsp_valid = t2_v;
    assign tlb_rsp_hit   = !t2_a[12];
    assign tlb_rsp_paddr = tlb_map(t2_a);

    function automatic logic [PA_W-1:0] tlb_map(input logic [VA_W-1:0] va);
        return va[PA_W-1:0] ^ 46'h2A5A_0000_0000;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [VA_W-1:0] va, input string req);
        exp_t e;
        logic [VA_W:0] sum;
        e.req = req;
        if (va >= m_base && va < m_limit) begin
            sum = {1'b0, va} + {1'b0, m_off};
            e.src   = 2'd1;
            e.fault = (sum[VA_W:PA_W] != '0);
            e.pa    = e.fault ? '0 : sum[PA_W-1:0];
        end else if (!va[12]) begin
            e.src = 2'd2; e.fault = 1'b0; e.pa = tlb_map(va);
        end else begin
            e.src = 2'd3; e.fault = 1'b0; e.pa = '0;
        end
        return e;
    endfunction

    function automatic void model_write(input logic [1:0] sel, input logic [VA_W-1:0] d);
        if (sel == 2'd2) m_off = d;
        else if (d[11:0] == 12'd0) begin
            if (sel == 2'd0) m_base = d;
            else if (sel == 2'd1) m_limit = d;
        end
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [VA_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(sel, d);
    endtask

    task automatic push_exp(input logic [VA_W-1:0] va, input string req);
        exp_t e;
        e = predict(va, req);
        rq.push_back(e);
        if (e.src == 2'd3) wq.push_back(va);
        n_req++;
    endtask

    // Optional register write in the same cycle as acceptance (wr=1).
    task automatic send_w(input logic [VA_W-1:0] va, input string req, input logic wr,
                          input logic [1:0] sel, input logic [VA_W-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        cfg_we = wr; cfg_sel = sel; cfg_wdata = d;
        push_exp(va, req);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (wr) model_write(sel, d);
        check(req_ready == 1'b0, "R11", "ready after accept", 64'(req_ready), 64'd0);
    endtask

    task automatic send(input logic [VA_W-1:0] va, input string req);
        send_w(va, req, 1'b0, 2'd3, '0);
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (tlb_lkp_valid) n_lkp++;
            if (rsp_valid) begin
                if (rq.size() == 0) begin
                    check(1'b0, "R5", "unexpected response", 64'(rsp_src), 64'd0);
                end else begin
                    exp_t e;
                    e = rq.pop_front();
                    check(rsp_src == e.src, e.req, "rsp_src", 64'(rsp_src), 64'(e.src));
                    check(rsp_paddr == e.pa, e.req, "rsp_paddr", 64'(rsp_paddr), 64'(e.pa));
                    check(rsp_fault == e.fault, e.req, "rsp_fault", 64'(rsp_fault), 64'(e.fault));
                end
            end
            if (walk_valid) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R5", "unexpected walk", 64'(walk_vaddr), 64'd0);
                end else begin
                    logic [VA_W-1:0] w;
                    w = wq.pop_front();
                    check(walk_vaddr == w, "R4", "walk_vaddr", 64'(walk_vaddr), 64'(w));
                end
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check(walk_valid == 1'b0, "R1", "walk_valid", 64'(walk_valid), 64'd0);
        send(48'h0000_0000_1000, "R1"); // empty segment, TLB miss
        send(48'h0000_0000_2000, "R4"); // TLB hit
        drain();

        // R2/R3: boundaries
        cfg_write(2'd0, 48'h0000_0010_0000);
        cfg_write(2'd1, 48'h0000_0020_0000);
        cfg_write(2'd2, 48'h0000_4000_0000);
        send(48'h0000_000F_FFFF, "R2");
        send(48'h0000_0010_0000, "R2");
        send(48'h0000_0012_3456, "R3");
        send(48'h0000_001F_FFFF, "R5"); // in segment, TLB would miss
        send(48'h0000_0020_0000, "R2");
        send(48'h0000_0020_1000, "R4");
        drain();

        // R6: unaligned base/limit writes ignored; select 3 ignored
        cfg_write(2'd0, 48'h0000_0010_0800);
        cfg_write(2'd1, 48'h0000_0030_0010);
        cfg_write(2'd3, 48'h0000_0000_0000);
        send(48'h0000_0010_0000, "R6");
        send(48'h0000_0020_0000, "R6");
        drain();

        // R8: grow and shrink at run time
        cfg_write(2'd1, 48'h0000_0040_0000);
        send(48'h0000_0030_1000, "R8");
        cfg_write(2'd0, 48'h0000_0018_0000);
        send(48'h0000_0010_0000, "R8");
        drain();

        // R7: empty and inverted segments
        cfg_write(2'd0, 48'h0000_0050_0000);
        cfg_write(2'd1, 48'h0000_0050_0000);
        send(48'h0000_0050_0000, "R7");
        cfg_write(2'd1, 48'h0000_0040_0000);
        send(48'h0000_0045_1000, "R7");
        send(48'h0000_0050_0000, "R7");
        drain();

        // R10: physical overflow edges
        cfg_write(2'd0, 48'h0000_1000_0000);
        cfg_write(2'd1, 48'h0000_2000_0000);
        cfg_write(2'd2, 48'h3FFF_EFFF_FFFF);
        send(48'h0000_1000_0000, "R10"); // sum = 2^46-1
        send(48'h0000_1000_0001, "R10"); // sum = 2^46
        cfg_write(2'd2, 48'hFFFF_FFFF_FFFF);
        send(48'h0000_1000_0000, "R10"); // carry out of 48 bits
        cfg_write(2'd2, 48'h0000_0000_0000);
        cfg_write(2'd0, 48'h8000_0000_0000);
        cfg_write(2'd1, 48'hF000_0000_0000);
        send(48'h8000_0000_0000, "R10");
        drain();

        // R9: write in acceptance cycle and while waiting
        cfg_write(2'd0, 48'h0000_0010_0000);
        cfg_write(2'd1, 48'h0000_0020_0000);
        cfg_write(2'd2, 48'h0000_0100_0000);
        send_w(48'h0000_0011_0000, "R9", 1'b1, 2'd2, 48'h0000_0200_0000);
        send(48'h0000_0011_0000, "R9");
        send_w(48'h0000_0020_0000, "R9", 1'b1, 2'd1, 48'h0000_0030_0000);
        send(48'h0000_0025_1000, "R9");
        cfg_write(2'd1, 48'h0000_0020_0000); // during WAIT of the request above
        send(48'h0000_0025_1000, "R9");
        drain();

        // R2: randomized boundary sweep
        for (int i = 0; i < 40; i++) begin
            logic [VA_W-1:0] b, l, o;
            b = {4'h0, 32'($urandom), 12'h000};
            l = b + {16'h0, 20'($urandom_range(1, 4096)), 12'h000};
            o = {16'h0, 32'($urandom)};
            cfg_write(2'd0, b);
            cfg_write(2'd1, l);
            cfg_write(2'd2, o);
            case (i % 4)
                0: send(b - 48'd1, "R2");
                1: send(b, "R2");
                2: send(l - 48'd1, "R2");
                default: send(l, "R2");
            endcase
        end
        drain();

        check(rq.size() == 0, "R5", "pending responses", 64'(rq.size()), 64'd0);
        check(wq.size() == 0, "R5", "pending walks", 64'(wq.size()), 64'd0);
        check(n_lkp == n_req, "R11", "lookup count", 64'(n_lkp), 64'(n_req));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule